// File: doc/BRIEF.md
# Pixel to Bus-Cycle Serializer

This block sits between a pixel source and the engine that drives the strobes of a parallel display bus. It accepts one pixel at a time over a valid/ready stream and turns each pixel into the sequence of bus words that the panel expects. How many words a pixel needs is set by two codes: the pixel format (12, 16, 18 or 24 bits) and the number of bus data lines (8, 9, 12 or 16). When the pixel width is a whole multiple of the bus width, each pixel becomes one, two or three words, most significant part first. When two pixels fit exactly in three bus words, the block packs them that way. The middle word then carries the low half-field of the first pixel next to the high half-field of the second.

Software loads the frame length (width times height) and pulses a start input. The block then reports busy, accepts exactly that many pixels and drops busy once the last bus word has been taken. In the same cycle it raises a one-cycle frame-done pulse. A format and width pair with no valid packing, or a zero frame length, is refused. The block stays idle and raises an error flag.

Top module: `pix_bus_serializer`

## Requirements
- R1: When pixel bits P are a multiple of bus lines L, each pixel yields P/L words. Word k (counting from 0) holds pixel bits [P-1-k*L : P-(k+1)*L], so the most significant part goes first.
- R2: When 2P/L equals 3, pixels are taken in pairs A,B with H=L/2, giving three words per pair. The first word is A[P-1:H]. The second is {A[H-1:0], B[P-1:2H]}, with the A half in its upper H bits. The third is B[L-1:0].
- R3: In the paired format, an unpaired final pixel A produces two words, A[P-1:H] and {A[H-1:0], H zero bits}, and the frame then ends.
- R4: A start with an illegal pair (12/9, 12/16, 16/9, 16/12, 18/8, 18/16, 24/9) or with a zero frame length sets cfg_err. Busy stays low, s_ready stays low and no word is sent. A later legal start clears cfg_err.
- R5: Pixel format code 0/1/2/3 means 12/16/18/24 bits. Bus width code 0/1/2/3 means 8/9/12/16 lines. Configuration is captured at start.
- R6: Every word is right-aligned in m_word, and bits at or above L are zero. Pixel bits at or above P are ignored.
- R7: While m_valid is high and m_ready is low, m_valid stays high and m_word does not change.
- R8: Start while idle raises busy in the next cycle. Exactly cfg_pix_total pixels are accepted. Busy falls with a one-cycle frame_done pulse in the cycle after the last word handshake, and s_ready stays low once the last pixel is in.
- R9: After reset, busy, cfg_err, frame_done, s_ready and m_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pix_fmt | input | 2 | Pixel format code |
| cfg_bus_width | input | 2 | Bus width code |
| cfg_pix_total | input | CNT_W | Pixels in the frame |
| start | input | 1 | Start pulse, taken when idle |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last start was refused |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| s_valid | input | 1 | Pixel valid |
| s_ready | output | 1 | Pixel accepted this cycle when valid |
| s_pixel | input | PIX_W | Pixel value, right-aligned |
| m_valid | output | 1 | Bus word valid |
| m_ready | input | 1 | Bus engine takes the word |
| m_word | output | BUS_W | Bus word, right-aligned |

## Verification
The hardest situation to reach is the paired format at frame end. An odd frame length must flush a lone pixel, while an even one must not leave a stale half-field behind for the next frame. The bench covers both by running paired-format frames with odd and even lengths back to back, including a single-pixel frame. The ready input toggles on an irregular pattern throughout, so the last word of each frame often stalls. This also exercises the end-of-frame handshake and the hold rule under back-pressure.

// File: rtl/pxser_pkg.sv
package pxser_pkg;
   typedef enum logic [1:0] {
      CF_ONE    = 2'd0,
      CF_TWO    = 2'd1,
      CF_THREE  = 2'd2,
      CF_3PER2  = 2'd3
   } cyc_fmt_e;

   function automatic int unsigned pix_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 12;
         2'd1:    return 16;
         2'd2:    return 18;
         default: return 24;
      endcase
   endfunction

   function automatic int unsigned bus_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 9;
         2'd2:    return 12;
         default: return 16;
      endcase
   endfunction
endpackage

// File: rtl/pxser_fmt_decode.sv
module pxser_fmt_decode
   import pxser_pkg::*;
(
   input  logic [1:0] pix_code,
   input  logic [1:0] bus_code,
   output logic       legal,
   output cyc_fmt_e   fmt,
   output logic [4:0] lines,
   output logic [3:0] half,
   output logic [5:0] pbits
);
   int unsigned p_w, l_w;

   always_comb begin
      p_w   = pix_bits(pix_code);
      l_w   = bus_bits(bus_code);
      legal = 1'b0;
      fmt   = CF_ONE;
      if ((p_w % l_w) == 0) begin
         case (p_w / l_w)
            1:       begin legal = 1'b1; fmt = CF_ONE;   end
            2:       begin legal = 1'b1; fmt = CF_TWO;   end
            3:       begin legal = 1'b1; fmt = CF_THREE; end
            default: legal = 1'b0;
         endcase
      end else if ((((2 * p_w) % l_w) == 0) && (((2 * p_w) / l_w) == 3)) begin
         legal = 1'b1;
         fmt   = CF_3PER2;
      end
      lines = 5'(l_w);
      half  = 4'(l_w / 2);
      pbits = 6'(p_w);
   end
endmodule

// File: rtl/pxser_pack.sv
module pxser_pack
   import pxser_pkg::*;
#(
   parameter int PIX_W = 24,
   parameter int BUS_W = 16
)(
   input  logic [PIX_W-1:0] pixel,
   input  cyc_fmt_e         fmt,
   input  logic [4:0]       lines,
   input  logic [3:0]       half,
   input  logic [5:0]       pbits,
   input  logic             phase,
   input  logic [BUS_W-1:0] a_lo,
   input  logic             is_last,
   output logic [BUS_W-1:0] w0,
   output logic [BUS_W-1:0] w1,
   output logic [BUS_W-1:0] w2,
   output logic [1:0]       nw,
   output logic [BUS_W-1:0] a_lo_nxt
);
   localparam int XW = 64;
   logic [XW-1:0] px, lmask, hmask;

   always_comb begin
      lmask    = (XW'(1) << lines) - XW'(1);
      hmask    = (XW'(1) << half) - XW'(1);
      px       = XW'(pixel) & ((XW'(1) << pbits) - XW'(1));
      w0       = '0;
      w1       = '0;
      w2       = '0;
      nw       = 2'd1;
      a_lo_nxt = a_lo;
      case (fmt)
         CF_ONE: w0 = BUS_W'(px & lmask);
         CF_TWO: begin
            w0 = BUS_W'((px >> lines) & lmask);
            w1 = BUS_W'(px & lmask);
            nw = 2'd2;
         end
         CF_THREE: begin
            w0 = BUS_W'((px >> {lines, 1'b0}) & lmask);
            w1 = BUS_W'((px >> lines) & lmask);
            w2 = BUS_W'(px & lmask);
            nw = 2'd3;
         end
         default: begin
            if (!phase) begin
               w0       = BUS_W'(px >> half);
               w1       = BUS_W'((px & hmask) << half);
               a_lo_nxt = BUS_W'(px & hmask);
               nw       = is_last ? 2'd2 : 2'd1;
            end else begin
               w0 = BUS_W'((XW'(a_lo) << half) | (px >> {half, 1'b0}));
               w1 = BUS_W'(px & lmask);
               nw = 2'd2;
            end
         end
      endcase
   end
endmodule

// File: rtl/pxser_count.sv
module pxser_count #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] total,
   input  logic             inc,
   output logic             is_last
);
   logic [CNT_W-1:0] cnt_q, total_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         total_q <= '0;
      end else if (load) begin
         cnt_q   <= '0;
         total_q <= total;
      end else if (inc) begin
         cnt_q   <= cnt_q + CNT_W'(1);
      end
   end

   assign is_last = (cnt_q + CNT_W'(1)) == total_q;

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= total_q);
endmodule

// File: rtl/pix_bus_serializer.sv
module pix_bus_serializer
   import pxser_pkg::*;
#(
   parameter int PIX_W = 24,
   parameter int BUS_W = 16,
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_pix_fmt,
   input  logic [1:0]       cfg_bus_width,
   input  logic [CNT_W-1:0] cfg_pix_total,
   input  logic             start,
   output logic             busy,
   output logic             cfg_err,
   output logic             frame_done,
   input  logic             s_valid,
   output logic             s_ready,
   input  logic [PIX_W-1:0] s_pixel,
   output logic             m_valid,
   input  logic             m_ready,
   output logic [BUS_W-1:0] m_word
);
   localparam int NWORDS = 3;

   if (PIX_W < 24 || PIX_W > 32) begin : g_bad_pix
      $error("PIX_W must lie in 24..32");
   end
   if (BUS_W < 16 || BUS_W > 32) begin : g_bad_bus
      $error("BUS_W must lie in 16..32");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic       d_legal;
   cyc_fmt_e   d_fmt;
   logic [4:0] d_lines;
   logic [3:0] d_half;
   logic [5:0] d_pbits;

   pxser_fmt_decode u_dec (
      .pix_code (cfg_pix_fmt),
      .bus_code (cfg_bus_width),
      .legal    (d_legal),
      .fmt      (d_fmt),
      .lines    (d_lines),
      .half     (d_half),
      .pbits    (d_pbits)
   );

   logic                       busy_q, err_q, done_q, phase_q, last_seen_q;
   cyc_fmt_e                   fmt_q;
   logic [4:0]                 lines_q;
   logic [3:0]                 half_q;
   logic [5:0]                 pbits_q;
   logic [NWORDS-1:0][BUS_W-1:0] words_q;
   logic [1:0]                 nw_q, idx_q;
   logic [BUS_W-1:0]           alo_q;

   logic             accept_cfg, px_fire, wd_fire, is_last;
   logic [BUS_W-1:0] b_w0, b_w1, b_w2, b_alo;
   logic [1:0]       b_nw;

   assign accept_cfg = start && !busy_q && d_legal && (cfg_pix_total != '0);
   assign m_valid    = idx_q != nw_q;
   assign s_ready    = busy_q && (nw_q == 2'd0) && !last_seen_q;
   assign px_fire    = s_valid && s_ready;
   assign wd_fire    = m_valid && m_ready;
   assign m_word     = m_valid ? words_q[idx_q] : '0;
   assign busy       = busy_q;
   assign cfg_err    = err_q;
   assign frame_done = done_q;

   pxser_count #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept_cfg),
      .total   (cfg_pix_total),
      .inc     (px_fire),
      .is_last (is_last)
   );

   pxser_pack #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_pack (
      .pixel    (s_pixel),
      .fmt      (fmt_q),
      .lines    (lines_q),
      .half     (half_q),
      .pbits    (pbits_q),
      .phase    (phase_q),
      .a_lo     (alo_q),
      .is_last  (is_last),
      .w0       (b_w0),
      .w1       (b_w1),
      .w2       (b_w2),
      .nw       (b_nw),
      .a_lo_nxt (b_alo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         err_q       <= 1'b0;
         done_q      <= 1'b0;
         phase_q     <= 1'b0;
         last_seen_q <= 1'b0;
         fmt_q       <= CF_ONE;
         lines_q     <= '0;
         half_q      <= '0;
         pbits_q     <= '0;
         words_q     <= '0;
         nw_q        <= '0;
         idx_q       <= '0;
         alo_q       <= '0;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) begin
            if (accept_cfg) begin
               busy_q      <= 1'b1;
               err_q       <= 1'b0;
               fmt_q       <= d_fmt;
               lines_q     <= d_lines;
               half_q      <= d_half;
               pbits_q     <= d_pbits;
               phase_q     <= 1'b0;
               last_seen_q <= 1'b0;
            end else begin
               err_q <= 1'b1;
            end
         end
         if (px_fire) begin
            words_q     <= {b_w2, b_w1, b_w0};
            nw_q        <= b_nw;
            idx_q       <= 2'd0;
            alo_q       <= b_alo;
            last_seen_q <= is_last;
            phase_q     <= (fmt_q == CF_3PER2) ? ~phase_q : 1'b0;
         end else if (wd_fire) begin
            if (idx_q == nw_q - 2'd1) begin
               idx_q <= 2'd0;
               nw_q  <= 2'd0;
               if (last_seen_q) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end else begin
               idx_q <= idx_q + 2'd1;
            end
         end
      end
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_word)));
   assert_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> ((64'(m_word) >> lines_q) == 64'd0));
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !busy);
   assert_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> frame_done);
   assert_err_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!busy && !m_valid));
   assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> !m_valid);
endmodule

// File: tb/pix_bus_serializer_bench.sv
module pix_bus_serializer_bench;
   localparam int PIX_W = 24;
   localparam int BUS_W = 16;
   localparam int CNT_W = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n = 1'b0;
   logic [1:0]       cfg_pix_fmt = '0, cfg_bus_width = '0;
   logic [CNT_W-1:0] cfg_pix_total = '0;
   logic             start = 1'b0;
   logic             busy, cfg_err, frame_done;
   logic             s_valid = 1'b0;
   logic             s_ready;
   logic [PIX_W-1:0] s_pixel = '0;
   logic             m_valid;
   logic             m_ready = 1'b0;
   logic [BUS_W-1:0] m_word;

   int checks = 0;
   int errors = 0;
   int done_seen = 0;
   logic [BUS_W-1:0] exp_q[$];
   string            tag_q[$];
   logic [31:0]      lcg = 32'h2468ace1;

   pix_bus_serializer #(.PIX_W(PIX_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_pix_bus_serializer (
      .clk(clk), .rst_n(rst_n), .cfg_pix_fmt(cfg_pix_fmt), .cfg_bus_width(cfg_bus_width),
      .cfg_pix_total(cfg_pix_total), .start(start), .busy(busy), .cfg_err(cfg_err),
      .frame_done(frame_done), .s_valid(s_valid), .s_ready(s_ready), .s_pixel(s_pixel),
      .m_valid(m_valid), .m_ready(m_ready), .m_word(m_word)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp,
                        input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int pbits_of(input logic [1:0] c);
      case (c) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
   endfunction

   function automatic int lbits_of(input logic [1:0] c);
      case (c) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
   endfunction

   // Monitor: drives m_ready at each falling edge and pops the scoreboard on a handshake.
   initial begin
      logic [BUS_W-1:0] held = '0;
      bit stalled = 1'b0;
      int cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (frame_done) done_seen++;
         if (stalled)
            check(m_valid && m_word == held, "R7", longint'(m_word), longint'(held), "held word");
         m_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
         stalled = m_valid && !m_ready;
         held    = m_word;
         if (m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", longint'(m_word), 0, "unexpected word");
            end else begin
               logic [BUS_W-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(m_word == e, t, longint'(m_word), longint'(e), "bus word");
            end
         end
      end
   end

   task automatic push_exp(input longint unsigned v, input string req);
      exp_q.push_back(BUS_W'(v));
      tag_q.push_back(req);
   endtask

   task automatic run_frame(input logic [1:0] pc, input logic [1:0] bc, input int npx,
                            input string req);
      int P, L, H, base;
      longint unsigned pm, lm, hm, a, b;
      logic [PIX_W-1:0] px[$];
      P = pbits_of(pc); L = lbits_of(bc); H = L / 2;
      pm = (64'd1 << P) - 1; lm = (64'd1 << L) - 1; hm = (64'd1 << H) - 1;
      base = done_seen;
      for (int i = 0; i < npx; i++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         px.push_back(lcg[29:6]);
      end
      if ((P % L) == 0) begin
         for (int i = 0; i < npx; i++) begin
            a = longint'(px[i]) & pm;
            for (int k = 0; k < P / L; k++)
               push_exp((a >> (L * (P / L - 1 - k))) & lm, req);
         end
      end else begin
         for (int i = 0; i < npx; i += 2) begin
            a = longint'(px[i]) & pm;
            push_exp(a >> H, req);
            if (i + 1 < npx) begin
               b = longint'(px[i+1]) & pm;
               push_exp(((a & hm) << H) | (b >> (2 * H)), req);
               push_exp(b & lm, req);
            end else begin
               push_exp((a & hm) << H, "R3");
            end
         end
      end
      @(negedge clk);
      cfg_pix_fmt = pc; cfg_bus_width = bc; cfg_pix_total = CNT_W'(npx); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R8", longint'(busy), 1, "busy after start");
      check(cfg_err === 1'b0, "R4", longint'(cfg_err), 0, "error cleared by legal start");
      for (int i = 0; i < npx; i++) begin
         s_pixel = px[i];
         s_valid = 1'b1;
         while (!s_ready) @(negedge clk);
         @(negedge clk);
      end
      s_valid = 1'b0;
      for (int t = 0; t < 2000 && busy; t++) @(negedge clk);
      @(negedge clk);
      check(busy === 1'b0, "R8", longint'(busy), 0, "busy after frame");
      check(done_seen == base + 1, "R8", done_seen - base, 1, "frame_done pulses");
      check(exp_q.size() == 0, req, exp_q.size(), 0, "words still expected");
   endtask

   task automatic try_bad(input logic [1:0] pc, input logic [1:0] bc, input int total);
      int base;
      base = done_seen;
      @(negedge clk);
      cfg_pix_fmt = pc; cfg_bus_width = bc; cfg_pix_total = CNT_W'(total); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(cfg_err === 1'b1, "R4", longint'(cfg_err), 1, "error flag");
      check(busy === 1'b0, "R4", longint'(busy), 0, "busy on refused start");
      s_valid = 1'b1;
      s_pixel = 24'hA5C3E1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(!s_ready && !m_valid, "R4", longint'({s_ready, m_valid}), 0, "idle while refused");
      end
      s_valid = 1'b0;
      check(done_seen == base, "R4", done_seen - base, 0, "no frame_done");
   endtask

   initial begin
      #400us;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check({busy, cfg_err, frame_done, s_ready, m_valid} == 5'b0, "R9",
            longint'({busy, cfg_err, frame_done, s_ready, m_valid}), 0, "reset outputs");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({busy, cfg_err, frame_done, s_ready, m_valid} == 5'b0, "R9",
            longint'({busy, cfg_err, frame_done, s_ready, m_valid}), 0, "after reset release");

      run_frame(2'd1, 2'd3, 4, "R1");   // 16 on 16
      run_frame(2'd1, 2'd0, 3, "R1");   // 16 on 8, high byte first
      run_frame(2'd3, 2'd0, 3, "R1");   // 24 on 8
      run_frame(2'd2, 2'd1, 3, "R5");   // 18 on 9
      run_frame(2'd3, 2'd2, 2, "R5");   // 24 on 12
      run_frame(2'd0, 2'd2, 3, "R6");   // 12 on 12, upper pixel bits ignored
      try_bad(2'd1, 2'd2, 4);           // 16 on 12
      run_frame(2'd0, 2'd0, 4, "R2");   // 12 on 8, paired
      run_frame(2'd3, 2'd3, 4, "R2");   // 24 on 16, paired
      try_bad(2'd2, 2'd0, 3);           // 18 on 8
      run_frame(2'd2, 2'd2, 3, "R3");   // 18 on 12, odd tail
      run_frame(2'd3, 2'd3, 1, "R3");   // single pixel
      run_frame(2'd0, 2'd0, 5, "R3");
      try_bad(2'd0, 2'd3, 2);           // 12 on 16
      try_bad(2'd1, 2'd3, 0);           // zero length
      run_frame(2'd1, 2'd0, 2, "R1");

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule